// File: doc/BRIEF.md
# Special-Purpose Register Access Controller

This block carries out the move-to and move-from operations on the special-purpose registers of a 32-bit CPU core. The pipeline presents one request at a time: a direction (read or write), a 16-bit register address, the write data, and the two status bits that grant access (supervisor mode, and user access to special registers). The controller checks privilege and range, then checks the address against separate lists of readable and writable registers. It applies the side effects some writes carry, and returns one registered response. The storage for the named registers and for a 512-entry shadow copy of the general registers sits inside the block.

A register address is the 5-bit group number shifted left by 11, combined with an 11-bit index. The addresses in use are listed below. The lists are deliberately asymmetric:

- The exception status register can be written but not read back.
- The version, unit-present, configuration and previous-PC registers can be read but not written.
- The next-PC register is never stored. A write to it turns into a fetch redirect.
- The tick-timer mode register only accepts a write of zero, which it then discards.

The control is a three-state machine:

- `ST_IDLE` accepts a request. Transition *accept*: `req_valid` with `req_ready` high.
- `ST_EXEC` decodes the captured request, commits any storage write and registers the response. Transition *execute*: unconditional.
- `ST_RESP` presents the response for exactly one cycle. Transition *retire*: unconditional, back to `ST_IDLE`.

Top module: `spr_access_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `err`, `redirect_valid` and `wr_en` are all 0. Reading the status register (address 0x0011) returns its reset value 0x00008001.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the next two cycles. The response outputs are valid in the second cycle after acceptance, with `resp_valid` high for exactly that one cycle.
- R3: If neither `sup_mode` nor `user_spr_ok` was set when the request was accepted, the access is refused. A read returns 0 with `err`. A write raises `err`, asserts no `wr_en` bit and changes no stored register.
- R4: Any address at or above `NUM_SPR` (default 0x6000) is rejected with `err`. A read of such an address returns 0.
- R5: Only the following addresses can be read; they return their value with `err` low:
  - version 0x0000 (`VER_VAL`, default 0x12000001)
  - unit-present 0x0001 (default 0x00000001)
  - configuration 0x0002 (default 0x00000020)
  - status 0x0011
  - previous PC 0x0012 (returns `ppc_in`)
  - FP control/status 0x0014
  - exception PC 0x0020
  - MAC low 0x2801
  - MAC high 0x2802
  - shadow range 0x0400..0x05FF

  Any other read, including exception status 0x0040, next PC 0x0010 and tick mode 0x5000, returns 0 with `err`.
- R6: Writes to FP control/status, exception PC, exception status 0x0040, MAC low, MAC high and the shadow range store the data unchanged. Writes to any address outside this list, R7, R8 and R9 raise `err` and store nothing.
- R7: A write to the status register stores the data with bit 15 forced to 1.
- R8: A write to the next-PC register stores nothing. In the response cycle it pulses `redirect_valid` with `redirect_pc` equal to the written data, which also tells the core to clear its pending delay-slot state. `err` stays low and no `wr_en` bit is set.
- R9: A write of zero to the tick-mode register is accepted with `err` low and no `wr_en` bit. A nonzero write raises `err`.
- R10: Each shadow address 0x0400 + k (k = 0..511) holds its own 32-bit value; 0x03FF and 0x0600 are not part of the range.
- R11: `wr_en` marks the register a committed write went to, with at most one bit set, valid in the response cycle:
  - bit 0 FP control/status
  - bit 1 exception PC
  - bit 2 exception status
  - bit 3 status
  - bit 4 MAC low
  - bit 5 MAC high
  - bit 6 shadow

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 16 | Register address (group << 11 \| index) |
| req_wdata | input | 32 | Write data |
| sup_mode | input | 1 | Supervisor mode status bit |
| user_spr_ok | input | 1 | User access to special registers allowed |
| ppc_in | input | 32 | Previous-PC value from the core |
| resp_valid | output | 1 | Response cycle |
| rd_data | output | 32 | Read result (0 on any refusal) |
| wr_en | output | 7 | Per-register write commit strobe |
| redirect_valid | output | 1 | Fetch redirect and delay-slot clear |
| redirect_pc | output | 32 | Redirect target |
| err | output | 1 | Privilege or address violation |

## Verification
A wrong decode shows up in the very response it produced. `err`, `wr_en` or `rd_data` differ from the expected values two cycles after acceptance. A state machine stuck outside `ST_IDLE` shows at once as `req_ready` staying low. A write that reached the wrong register, or that should have been dropped, stays hidden until a later read of that address. For that reason the directed tests read back after every write, after refused writes and after writes to addresses that are not on the list. The read-back confirms stored values such as the forced status bit and the separate shadow entries.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int SPR_AW    = 16;
    localparam int GRP_SHIFT = 11;
    localparam int WEN_W     = 7;

    // special-purpose register identity after decode
    typedef enum logic [3:0] {
        ID_NONE, ID_VER, ID_UPR, ID_CFG, ID_NPC, ID_SR, ID_PPC,
        ID_FPCSR, ID_EPCR, ID_ESR, ID_MACLO, ID_MACHI, ID_TTMR, ID_SHADOW
    } spr_id_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_EXEC, ST_RESP
    } spr_state_e;

    function automatic logic [SPR_AW-1:0] spr_addr(input int unsigned grp,
                                                  input int unsigned idx);
        return SPR_AW'((grp << GRP_SHIFT) | idx);
    endfunction

    localparam logic [SPR_AW-1:0] A_VER   = spr_addr(0, 0);
    localparam logic [SPR_AW-1:0] A_UPR   = spr_addr(0, 1);
    localparam logic [SPR_AW-1:0] A_CFG   = spr_addr(0, 2);
    localparam logic [SPR_AW-1:0] A_NPC   = spr_addr(0, 16);
    localparam logic [SPR_AW-1:0] A_SR    = spr_addr(0, 17);
    localparam logic [SPR_AW-1:0] A_PPC   = spr_addr(0, 18);
    localparam logic [SPR_AW-1:0] A_FPCSR = spr_addr(0, 20);
    localparam logic [SPR_AW-1:0] A_EPCR  = spr_addr(0, 32);
    localparam logic [SPR_AW-1:0] A_ESR   = spr_addr(0, 64);
    localparam logic [SPR_AW-1:0] A_MACLO = spr_addr(5, 1);
    localparam logic [SPR_AW-1:0] A_MACHI = spr_addr(5, 2);
    localparam logic [SPR_AW-1:0] A_TTMR  = spr_addr(10, 0);

    function automatic logic can_read(input spr_id_e id);
        logic ok;
        unique case (id)
            ID_VER, ID_UPR, ID_CFG, ID_SR, ID_PPC, ID_FPCSR,
            ID_EPCR, ID_MACLO, ID_MACHI, ID_SHADOW: ok = 1'b1;
            default:                                ok = 1'b0;
        endcase
        return ok;
    endfunction

    // registers whose write commits into storage (status included)
    function automatic logic [WEN_W-1:0] wen_bit(input spr_id_e id);
        logic [WEN_W-1:0] w;
        w = '0;
        unique case (id)
            ID_FPCSR:  w[0] = 1'b1;
            ID_EPCR:   w[1] = 1'b1;
            ID_ESR:    w[2] = 1'b1;
            ID_SR:     w[3] = 1'b1;
            ID_MACLO:  w[4] = 1'b1;
            ID_MACHI:  w[5] = 1'b1;
            ID_SHADOW: w[6] = 1'b1;
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/spr_decode.sv
module spr_decode
    import spr_pkg::*;
#(
    parameter int unsigned NUM_SPR  = 'h6000,
    parameter int unsigned SH_BASE  = 'h400,
    parameter int unsigned SHADOW_N = 512,
    localparam int SH_AW = $clog2(SHADOW_N),
    localparam int IDX_W = GRP_SHIFT
)(
    input  logic [SPR_AW-1:0] addr,
    output logic              in_range,
    output spr_id_e           id,
    output logic [SH_AW-1:0]  sh_idx
);
    logic [SPR_AW-GRP_SHIFT-1:0] grp;
    logic [IDX_W-1:0]            idx;
    logic [IDX_W-1:0]            off;
    logic                        is_shadow;

    assign grp = addr[SPR_AW-1:GRP_SHIFT];
    assign idx = addr[IDX_W-1:0];
    assign off = idx - IDX_W'(SH_BASE);
    assign is_shadow = (grp == '0) && (idx >= IDX_W'(SH_BASE))
                       && (32'(off) < SHADOW_N);
    assign sh_idx   = off[SH_AW-1:0];
    assign in_range = (32'(addr) < NUM_SPR);

    always_comb begin
        if      (addr == A_VER)   id = ID_VER;
        else if (addr == A_UPR)   id = ID_UPR;
        else if (addr == A_CFG)   id = ID_CFG;
        else if (addr == A_NPC)   id = ID_NPC;
        else if (addr == A_SR)    id = ID_SR;
        else if (addr == A_PPC)   id = ID_PPC;
        else if (addr == A_FPCSR) id = ID_FPCSR;
        else if (addr == A_EPCR)  id = ID_EPCR;
        else if (addr == A_ESR)   id = ID_ESR;
        else if (addr == A_MACLO) id = ID_MACLO;
        else if (addr == A_MACHI) id = ID_MACHI;
        else if (addr == A_TTMR)  id = ID_TTMR;
        else if (is_shadow)       id = ID_SHADOW;
        else                      id = ID_NONE;
    end
endmodule

// File: rtl/spr_store.sv
module spr_store
    import spr_pkg::*;
#(
    parameter int unsigned SHADOW_N = 512,
    parameter int          DW       = 32,
    parameter logic [31:0] VER_VAL  = 32'h1200_0001,
    parameter logic [31:0] UPR_VAL  = 32'h0000_0001,
    parameter logic [31:0] CFG_VAL  = 32'h0000_0020,
    parameter logic [31:0] SR_RST   = 32'h0000_8001,
    parameter int          FO_BIT   = 15,
    localparam int SH_AW = $clog2(SHADOW_N)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  spr_id_e          id,
    input  logic [SH_AW-1:0] sh_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    ppc_in,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] sr_q, fpcsr_q, epcr_q, esr_q, maclo_q, machi_q;
    logic [DW-1:0] shadow_mem [SHADOW_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= DW'(SR_RST);
            fpcsr_q <= '0;
            epcr_q  <= '0;
            esr_q   <= '0;
            maclo_q <= '0;
            machi_q <= '0;
        end else if (wr_stb) begin
            unique case (id)
                ID_SR:    sr_q    <= wr_data | (DW'(1) << FO_BIT);
                ID_FPCSR: fpcsr_q <= wr_data;
                ID_EPCR:  epcr_q  <= wr_data;
                ID_ESR:   esr_q   <= wr_data;
                ID_MACLO: maclo_q <= wr_data;
                ID_MACHI: machi_q <= wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_stb && id == ID_SHADOW) shadow_mem[sh_idx] <= wr_data;
    end

    always_comb begin
        unique case (id)
            ID_VER:    rd_data = DW'(VER_VAL);
            ID_UPR:    rd_data = DW'(UPR_VAL);
            ID_CFG:    rd_data = DW'(CFG_VAL);
            ID_SR:     rd_data = sr_q;
            ID_PPC:    rd_data = ppc_in;
            ID_FPCSR:  rd_data = fpcsr_q;
            ID_EPCR:   rd_data = epcr_q;
            ID_ESR:    rd_data = esr_q;
            ID_MACLO:  rd_data = maclo_q;
            ID_MACHI:  rd_data = machi_q;
            ID_SHADOW: rd_data = shadow_mem[sh_idx];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spr_access_ctrl.sv
module spr_access_ctrl
    import spr_pkg::*;
#(
    parameter int unsigned NUM_SPR  = 'h6000,
    parameter int unsigned SH_BASE  = 'h400,
    parameter int unsigned SHADOW_N = 512,
    parameter logic [31:0] VER_VAL  = 32'h1200_0001,
    parameter logic [31:0] UPR_VAL  = 32'h0000_0001,
    parameter logic [31:0] CFG_VAL  = 32'h0000_0020,
    localparam int SH_AW = $clog2(SHADOW_N)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [15:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              sup_mode,
    input  logic              user_spr_ok,
    input  logic [31:0]       ppc_in,
    output logic              resp_valid,
    output logic [31:0]       rd_data,
    output logic [6:0]        wr_en,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc,
    output logic              err
);
    spr_state_e state_q, state_d;

    logic              q_write, q_priv;
    logic [15:0]       q_addr;
    logic [31:0]       q_wdata;

    logic              in_range;
    spr_id_e           id;
    logic [SH_AW-1:0]  sh_idx;
    logic [31:0]       store_rd;

    logic              n_err, n_redir, n_commit;
    logic [31:0]       n_rd;
    logic [WEN_W-1:0]  n_wen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EXEC : ST_IDLE;  // accept
            ST_EXEC: state_d = ST_RESP;                        // execute
            ST_RESP: state_d = ST_IDLE;                        // retire
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);

    // request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_priv  <= 1'b0;
            q_addr  <= '0;
            q_wdata <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            q_write <= req_write;
            q_priv  <= sup_mode | user_spr_ok;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
        end
    end

    spr_decode #(.NUM_SPR(NUM_SPR), .SH_BASE(SH_BASE), .SHADOW_N(SHADOW_N)) u_dec (
        .addr(q_addr), .in_range(in_range), .id(id), .sh_idx(sh_idx)
    );

    spr_store #(.SHADOW_N(SHADOW_N), .DW(32), .VER_VAL(VER_VAL),
                .UPR_VAL(UPR_VAL), .CFG_VAL(CFG_VAL)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(n_commit && state_q == ST_EXEC),
        .id(id), .sh_idx(sh_idx), .wr_data(q_wdata),
        .ppc_in(ppc_in), .rd_data(store_rd)
    );

    // outcome of the captured request
    always_comb begin
        n_err    = 1'b0;
        n_redir  = 1'b0;
        n_commit = 1'b0;
        n_rd     = '0;
        n_wen    = '0;
        if (!q_priv || !in_range) begin
            n_err = 1'b1;
        end else if (q_write) begin
            if (wen_bit(id) != '0) begin
                n_commit = 1'b1;
                n_wen    = wen_bit(id);
            end else if (id == ID_NPC) begin
                n_redir = 1'b1;
            end else if (id == ID_TTMR) begin
                n_err = (q_wdata != '0);
            end else begin
                n_err = 1'b1;
            end
        end else if (can_read(id)) begin
            n_rd = store_rd;
        end else begin
            n_err = 1'b1;
        end
    end

    // output process: loaded in ST_EXEC, shown for the ST_RESP cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid     <= 1'b0;
            rd_data        <= '0;
            wr_en          <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            err            <= 1'b0;
        end else if (state_q == ST_EXEC) begin
            resp_valid     <= 1'b1;
            rd_data        <= n_rd;
            wr_en          <= n_wen;
            redirect_valid <= n_redir;
            redirect_pc    <= n_redir ? q_wdata : '0;
            err            <= n_err;
        end else begin
            resp_valid     <= 1'b0;
            rd_data        <= '0;
            wr_en          <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            err            <= 1'b0;
        end
    end

    a_r2_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r2_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r3_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !q_priv) |=>
            (err && wr_en == '0 && rd_data == '0 && !redirect_valid));
    a_r4_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && !in_range) |=> (err && rd_data == '0));
    a_r8_redirect_clean: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (resp_valid && !err && wr_en == '0));
    a_r11_wen_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en) && (wr_en == '0 || resp_valid));
endmodule

// File: tb/test_spr_access_ctrl.sv
module test_spr_access_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        sup_mode = 1'b0, user_spr_ok = 1'b0;
    logic [31:0] ppc_in = 32'hCAFE_0010;
    logic        req_ready, resp_valid, redirect_valid, err;
    logic [31:0] rd_data, redirect_pc;
    logic [6:0]  wr_en;

    int total = 0, bad = 0;
    bit done = 0;

    localparam logic [15:0] A_VER = 16'h0000, A_UPR = 16'h0001, A_CFG = 16'h0002;
    localparam logic [15:0] A_NPC = 16'h0010, A_SR = 16'h0011, A_PPC = 16'h0012;
    localparam logic [15:0] A_FP  = 16'h0014, A_EPC = 16'h0020, A_ESR = 16'h0040;
    localparam logic [15:0] A_MLO = 16'h2801, A_MHI = 16'h2802, A_TT = 16'h5000;

    always #10 clk = ~clk;

    spr_access_ctrl i_spr_access_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .sup_mode(sup_mode), .user_spr_ok(user_spr_ok), .ppc_in(ppc_in),
        .resp_valid(resp_valid), .rd_data(rd_data), .wr_en(wr_en),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .err(err)
    );

    logic [31:0] r_data, r_pc;
    logic        r_err, r_redir;
    logic [6:0]  r_wen;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; response sampled two edges after acceptance
    task automatic acc(input bit w, input logic [15:0] a, input logic [31:0] d,
                       input bit sm, input bit su);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        sup_mode = sm; user_spr_ok = su;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy after accept", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R2 response cycle", {30'b0, resp_valid, req_ready}, 32'd2);
        r_data = rd_data; r_err = err; r_wen = wr_en;
        r_redir = redirect_valid; r_pc = redirect_pc;
        @(negedge clk);
        chk("R2 single response", {30'b0, resp_valid, req_ready}, 32'd1);
    endtask

    task automatic rd_ok(input string req, input logic [15:0] a, input logic [31:0] exp);
        acc(0, a, 32'h0, 1, 0);
        chk(req, r_data, exp);
        chk(req, {31'b0, r_err}, 32'd0);
    endtask

    task automatic rd_bad(input string req, input logic [15:0] a);
        acc(0, a, 32'h0, 1, 0);
        chk(req, r_data, 32'd0);
        chk(req, {31'b0, r_err}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 outputs idle", {22'b0, resp_valid, err, redirect_valid, wr_en}, 32'd0);
        rd_ok("R1 status reset value", A_SR, 32'h0000_8001);
    endtask

    task automatic t_constants;
        rd_ok("R5 version", A_VER, 32'h1200_0001);
        rd_ok("R5 unit-present", A_UPR, 32'h0000_0001);
        rd_ok("R5 config", A_CFG, 32'h0000_0020);
        rd_ok("R5 previous pc", A_PPC, 32'hCAFE_0010);
    endtask

    task automatic t_plain_writes;
        acc(1, A_FP, 32'h0000_00A5, 1, 0);
        chk("R11 fpcsr wen bit0", {25'b0, r_wen}, 32'h01);
        chk("R6 fpcsr err", {31'b0, r_err}, 32'd0);
        acc(1, A_EPC, 32'h1000_2000, 0, 1);
        chk("R11 epcr wen bit1", {25'b0, r_wen}, 32'h02);
        acc(1, A_MLO, 32'h1111_2222, 1, 0);
        chk("R11 maclo wen bit4", {25'b0, r_wen}, 32'h10);
        acc(1, A_MHI, 32'h3333_4444, 1, 0);
        chk("R11 machi wen bit5", {25'b0, r_wen}, 32'h20);
        rd_ok("R6 fpcsr readback", A_FP, 32'h0000_00A5);
        rd_ok("R6 epcr readback", A_EPC, 32'h1000_2000);
        rd_ok("R6 maclo readback", A_MLO, 32'h1111_2222);
        rd_ok("R6 machi readback", A_MHI, 32'h3333_4444);
    endtask

    task automatic t_esr_asym;
        acc(1, A_ESR, 32'h0000_0777, 1, 0);
        chk("R6 esr write wen bit2", {25'b0, r_wen}, 32'h04);
        chk("R6 esr write err", {31'b0, r_err}, 32'd0);
        rd_bad("R5 esr not readable", A_ESR);
    endtask

    task automatic t_privilege;
        acc(0, A_VER, 32'h0, 0, 0);
        chk("R3 refused read data", r_data, 32'd0);
        chk("R3 refused read err", {31'b0, r_err}, 32'd1);
        acc(1, A_EPC, 32'hDEAD_BEEF, 0, 0);
        chk("R3 refused write err", {31'b0, r_err}, 32'd1);
        chk("R3 refused write wen", {25'b0, r_wen}, 32'd0);
        rd_ok("R3 epcr unchanged", A_EPC, 32'h1000_2000);
    endtask

    task automatic t_range;
        rd_bad("R4 read at limit", 16'h6000);
        rd_bad("R4 read far above", 16'hF801);
        acc(1, 16'h6000, 32'h5, 1, 0);
        chk("R4 write at limit err", {31'b0, r_err}, 32'd1);
        chk("R4 write at limit wen", {25'b0, r_wen}, 32'd0);
    endtask

    task automatic t_status;
        acc(1, A_SR, 32'h0000_0004, 1, 0);
        chk("R11 sr wen bit3", {25'b0, r_wen}, 32'h08);
        rd_ok("R7 fixed-one bit forced", A_SR, 32'h0000_8004);
    endtask

    task automatic t_next_pc;
        acc(1, A_NPC, 32'h0000_4A00, 1, 0);
        chk("R8 redirect pulse", {31'b0, r_redir}, 32'd1);
        chk("R8 redirect target", r_pc, 32'h0000_4A00);
        chk("R8 no err", {31'b0, r_err}, 32'd0);
        chk("R8 no wen", {25'b0, r_wen}, 32'd0);
        rd_bad("R5 next pc not readable", A_NPC);
    endtask

    task automatic t_tick;
        acc(1, A_TT, 32'h0, 1, 0);
        chk("R9 zero accepted", {31'b0, r_err}, 32'd0);
        chk("R9 zero not stored", {25'b0, r_wen}, 32'd0);
        acc(1, A_TT, 32'h0000_0100, 1, 0);
        chk("R9 nonzero err", {31'b0, r_err}, 32'd1);
        chk("R9 nonzero no wen", {25'b0, r_wen}, 32'd0);
        rd_bad("R5 tick not readable", A_TT);
    endtask

    task automatic t_shadow;
        acc(1, 16'h0400, 32'hAAAA_0000, 1, 0);
        chk("R11 shadow wen bit6", {25'b0, r_wen}, 32'h40);
        acc(1, 16'h05FF, 32'hBBBB_01FF, 1, 0);
        acc(1, 16'h0401, 32'hCCCC_0001, 0, 1);
        rd_ok("R10 shadow first", 16'h0400, 32'hAAAA_0000);
        rd_ok("R10 shadow last", 16'h05FF, 32'hBBBB_01FF);
        rd_ok("R10 shadow second", 16'h0401, 32'hCCCC_0001);
        rd_bad("R10 below range", 16'h03FF);
        rd_bad("R10 above range", 16'h0600);
    endtask

    task automatic t_unlisted;
        acc(1, A_VER, 32'h1, 1, 0);
        chk("R6 version write err", {31'b0, r_err}, 32'd1);
        chk("R6 version write wen", {25'b0, r_wen}, 32'd0);
        rd_ok("R6 version unchanged", A_VER, 32'h1200_0001);
        acc(1, 16'h0030, 32'h9, 1, 0);
        chk("R6 unassigned write err", {31'b0, r_err}, 32'd1);
        rd_bad("R5 unassigned read", 16'h0030);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_constants;
        t_plain_writes;
        t_esr_asym;
        t_privilege;
        t_range;
        t_status;
        t_next_pc;
        t_tick;
        t_shadow;
        t_unlisted;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule